// File: doc/BRIEF.md
# Two-Operator Phase Modulation Amplitude Unit

This block works out the instantaneous output level of one synthesis voice built from two operators. A modulator operator turns a scaled phase into a signed wave value. Twice that value is added into the carrier's phase. The carrier then produces the final signed amplitude. Both operators work in the log domain. A quarter-wave log-sine table, mirrored into a full 1024-step cycle, gives an attenuation. The operator's level is added to it, and an exponential table turns the sum back into a linear magnitude.

Each request carries a frequency number, an octave shift, a multiplier for each operator, a modulator level, a carrier volume and a flag that switches the modulation path on. Requests arrive on a valid/ready stream and results leave on another valid/ready stream. The datapath is a five-register pipeline. When the consumer keeps `out_ready` high, it takes one request per cycle. When a finished result is waiting and `out_ready` is low, the whole pipeline freezes and `in_ready` drops in the same cycle. A producer may hold `in_valid` for as long as it likes. A request is taken only in a cycle where `in_valid` and `in_ready` are both high.

Top module: `pm_amp_unit`

## Requirements
- R1: The base phase is `fnum << block`. The modulator table index is `((base * mul_mod) >> 10) mod 1024`. The carrier's own index is `((base * mul_car) >> 10) mod 1024`.
- R2: Each index `x` (10 bits) is folded onto the quarter table. Bit 9 set means the value is negative. Bit 8 set means the lower 8 bits are inverted (`255 - x[7:0]`) before lookup.
- R3: Quarter-table entry `i`, with `p = 2i+1`: `s = (16*p*(1024-p) << 16) / (5*1024*1024 - 4*p*(1024-p))` (integer division). Let `n` be the position of the highest set bit of `s`. Let `f` be the 8 bits just below that bit, zero-filled when `n < 8`. The entry is `(16-n)*256 - ((f*(88320 - 89*f)) >> 16)`.
- R4: For an attenuation `a`, take `g = 255 - a[7:0]` and `k = a >> 8`. The magnitude is `(1024 + ((g*(172032 + 352*g)) >> 16)) >> k`.
- R5: The modulator value is `magnitude(table + 32*mod_level) >> 1`, negated when R2 marks it negative.
- R6: With `mod_en` set, twice the modulator value is added to the carrier index, modulo 1024. With `mod_en` clear, the modulator level and modulator multiplier have no effect on the output.
- R7: `out_amp` is `magnitude(table + 128*car_vol) >> 4` in 8-bit two's complement, negated when the carrier index is negative. It never reaches -128.
- R8: With `out_ready` held high, a request accepted on one clock edge gives `out_valid` after the fourth edge that follows. Back-to-back requests are all accepted without a gap.
- R9: While `out_valid` is high and `out_ready` is low, `out_amp` and `out_valid` hold and `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R10: While `rst` is high, `out_valid` is cleared by the next clock edge. Once `rst` is released, `in_ready` is high.
- R11: An attenuation whose integer part `a >> 8` is 11 or more gives magnitude zero, so a heavily attenuated carrier outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_fnum | input | 8 | Frequency number 0..255 |
| in_block | input | 3 | Octave left shift |
| in_mul_mod | input | 4 | Modulator phase multiplier |
| in_mul_car | input | 4 | Carrier phase multiplier |
| in_mod_level | input | 6 | Modulator attenuation level |
| in_car_vol | input | 4 | Carrier volume attenuation |
| in_mod_en | input | 1 | Adds modulator output into the carrier phase |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_amp | output | 8 | Signed carrier amplitude |

## Verification
The properties assume that the consumer obeys the stream rules. They take `out_ready` as free to change in any cycle. They also assume that once reset is released it stays released, so the frozen-output and in-ready relations are checked only outside reset. The stimulus changes `out_ready` only away from the clock edge. It runs phases with `out_ready` held high, held low for a long stretch, and toggled at random. Request fields stay inside their declared widths, so every index, attenuation and multiplier product the properties depend on is one the block can legally see.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int PHASE_W  = 10;
  localparam int LOG_W    = 12;
  localparam int MANT_W   = 10;
  localparam int MAG_W    = 11;
  localparam int ATTEN_W  = 13;
  localparam int PH_SHIFT = 10;

  // Quarter-wave log attenuation entry: rational sine estimate, then
  // integer log2 with a quadratic fractional correction.
  function automatic logic [LOG_W-1:0] lsin_calc(input int unsigned qi,
                                                 input int unsigned qn);
    logic [63:0] span, p, num, den, s, f, lf;
    int n;
    span = 64'(4 * qn);
    p    = 64'(2 * qi + 1);
    num  = (64'd16 * p * (span - p)) << 16;
    den  = 64'd5 * span * span - 64'd4 * p * (span - p);
    s    = num / den;
    n    = 0;
    for (int b = 0; b < 40; b++) begin
      if ((s >> b) != 64'd0) n = b;
    end
    if (n >= 8) f = (s >> (n - 8)) & 64'hFF;
    else        f = (s << (8 - n)) & 64'hFF;
    lf = (f * (64'd88320 - 64'd89 * f)) >> 16;
    return LOG_W'(64'(16 - n) * 64'd256 - lf);
  endfunction

  // Fractional part of 2^(g/256) scaled by 1024, quadratic estimate.
  function automatic logic [MANT_W-1:0] exp_calc(input int unsigned g);
    logic [63:0] x;
    x = 64'(g);
    return MANT_W'((x * (64'd172032 + 64'd352 * x)) >> 16);
  endfunction

endpackage

// File: rtl/pmu_phase.sv
module pmu_phase #(
  parameter int FNUM_W = 8,
  parameter int BLK_W  = 3,
  parameter int MUL_W  = 4
) (
  input  logic [FNUM_W-1:0]           fnum,
  input  logic [BLK_W-1:0]            blk,
  input  logic [MUL_W-1:0]            mul,
  output logic [pmu_pkg::PHASE_W-1:0] idx
);
  localparam int BASE_W = FNUM_W + (1 << BLK_W) - 1;
  localparam int RAW_W  = BASE_W + MUL_W;
  localparam int NEED_W = pmu_pkg::PH_SHIFT + pmu_pkg::PHASE_W;
  localparam int PROD_W = (RAW_W > NEED_W) ? RAW_W : NEED_W;

  logic [BASE_W-1:0] base;
  logic [PROD_W-1:0] prod;

  always_comb begin
    base = BASE_W'(fnum) << blk;
    prod = PROD_W'(base) * PROD_W'(mul);
    idx  = prod[pmu_pkg::PH_SHIFT +: pmu_pkg::PHASE_W];
  end
endmodule

// File: rtl/pmu_logsin.sv
module pmu_logsin (
  input  logic [pmu_pkg::PHASE_W-1:0] idx,
  output logic                        neg,
  output logic [pmu_pkg::LOG_W-1:0]   atten
);
  localparam int QW = pmu_pkg::PHASE_W - 2;
  localparam int QN = 1 << QW;

  logic [pmu_pkg::LOG_W-1:0] rom [QN];
  logic [QW-1:0]             q;

  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = pmu_pkg::lsin_calc(g, QN);
  end

  always_comb begin
    q     = idx[QW] ? ~idx[QW-1:0] : idx[QW-1:0];
    neg   = idx[pmu_pkg::PHASE_W-1];
    atten = rom[q];
  end
endmodule

// File: rtl/pmu_exp.sv
module pmu_exp (
  input  logic [pmu_pkg::ATTEN_W-1:0] atten,
  output logic [pmu_pkg::MAG_W-1:0]   mag
);
  localparam int FW    = 8;
  localparam int SH_W  = pmu_pkg::ATTEN_W - FW;
  localparam int EN    = 1 << FW;

  logic [pmu_pkg::MANT_W-1:0] rom [EN];
  logic [FW-1:0]              g;
  logic [SH_W-1:0]            sh;
  logic [pmu_pkg::MAG_W-1:0]  mant;

  for (genvar e = 0; e < EN; e++) begin : g_rom
    assign rom[e] = pmu_pkg::exp_calc(e);
  end

  always_comb begin
    g    = ~atten[FW-1:0];
    sh   = atten[pmu_pkg::ATTEN_W-1:FW];
    mant = pmu_pkg::MAG_W'(1 << pmu_pkg::MANT_W) + pmu_pkg::MAG_W'(rom[g]);
    if (int'(sh) >= pmu_pkg::MAG_W) mag = '0;
    else                            mag = mant >> sh;
  end
endmodule

// File: rtl/pm_amp_unit.sv
module pm_amp_unit #(
  parameter int FNUM_W = 8,
  parameter int BLK_W  = 3,
  parameter int MUL_W  = 4,
  parameter int TL_W   = 6,
  parameter int VOL_W  = 4,
  parameter int OUT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FNUM_W-1:0]       in_fnum,
  input  logic [BLK_W-1:0]        in_block,
  input  logic [MUL_W-1:0]        in_mul_mod,
  input  logic [MUL_W-1:0]        in_mul_car,
  input  logic [TL_W-1:0]         in_mod_level,
  input  logic [VOL_W-1:0]        in_car_vol,
  input  logic                    in_mod_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_amp
);
  import pmu_pkg::*;

  localparam int TL_SH   = 5;
  localparam int VOL_SH  = 7;
  localparam int MOD_SH  = 1;
  localparam int CAR_SH  = 4;
  localparam int MODV_W  = MAG_W - MOD_SH;
  localparam int CARM_W  = MAG_W - CAR_SH;
  localparam int STAGES  = 5;

  logic              adv;
  logic [STAGES-1:0] vld;

  assign adv       = !(vld[STAGES-1] && !out_ready);
  assign in_ready  = adv;
  assign out_valid = vld[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)      vld <= '0;
    else if (adv) vld <= {vld[STAGES-2:0], in_valid};
  end

  // Stage A: phase indices
  logic [PHASE_W-1:0] m_idx_c, c_idx_c;
  pmu_phase #(.FNUM_W(FNUM_W), .BLK_W(BLK_W), .MUL_W(MUL_W)) u_ph_mod (
    .fnum(in_fnum), .blk(in_block), .mul(in_mul_mod), .idx(m_idx_c));
  pmu_phase #(.FNUM_W(FNUM_W), .BLK_W(BLK_W), .MUL_W(MUL_W)) u_ph_car (
    .fnum(in_fnum), .blk(in_block), .mul(in_mul_car), .idx(c_idx_c));

  logic [PHASE_W-1:0] a_midx, a_cbase;
  logic [TL_W-1:0]    a_tl;
  logic [VOL_W-1:0]   a_vol;
  logic               a_en;

  always_ff @(posedge clk) begin
    if (adv) begin
      a_midx  <= m_idx_c;
      a_cbase <= c_idx_c;
      a_tl    <= in_mod_level;
      a_vol   <= in_car_vol;
      a_en    <= in_mod_en && in_valid;
    end
  end

  // Stage B: modulator log-sine plus level
  logic               m_neg_c;
  logic [LOG_W-1:0]   m_ls_c;
  pmu_logsin u_ls_mod (.idx(a_midx), .neg(m_neg_c), .atten(m_ls_c));

  logic [ATTEN_W-1:0] b_att;
  logic               b_neg, b_en;
  logic [PHASE_W-1:0] b_cbase;
  logic [VOL_W-1:0]   b_vol;

  always_ff @(posedge clk) begin
    if (adv) begin
      b_att   <= ATTEN_W'(m_ls_c) + (ATTEN_W'(a_tl) << TL_SH);
      b_neg   <= m_neg_c;
      b_en    <= a_en;
      b_cbase <= a_cbase;
      b_vol   <= a_vol;
    end
  end

  // Stage C: modulator magnitude, fold into carrier phase
  logic [MAG_W-1:0]   m_mag_c;
  logic [MODV_W-1:0]  m_val_c;
  logic [PHASE_W-1:0] m_dbl_c, m_off_c;
  pmu_exp u_ex_mod (.atten(b_att), .mag(m_mag_c));

  always_comb begin
    m_val_c = m_mag_c[MAG_W-1:MOD_SH];
    m_dbl_c = PHASE_W'({m_val_c, 1'b0});
    if (!b_en)      m_off_c = '0;
    else if (b_neg) m_off_c = PHASE_W'(0) - m_dbl_c;
    else            m_off_c = m_dbl_c;
  end

  logic [PHASE_W-1:0] c_cidx;
  logic [VOL_W-1:0]   c_vol;

  always_ff @(posedge clk) begin
    if (adv) begin
      c_cidx <= b_cbase + m_off_c;
      c_vol  <= b_vol;
    end
  end

  // Stage D: carrier log-sine plus volume
  logic             c_neg_c;
  logic [LOG_W-1:0] c_ls_c;
  pmu_logsin u_ls_car (.idx(c_cidx), .neg(c_neg_c), .atten(c_ls_c));

  logic [ATTEN_W-1:0] d_att;
  logic               d_neg;

  always_ff @(posedge clk) begin
    if (adv) begin
      d_att <= ATTEN_W'(c_ls_c) + (ATTEN_W'(c_vol) << VOL_SH);
      d_neg <= c_neg_c;
    end
  end

  // Stage E: carrier magnitude and sign
  logic [MAG_W-1:0]  c_mag_c;
  logic [OUT_W-1:0]  c_abs_c;
  pmu_exp u_ex_car (.atten(d_att), .mag(c_mag_c));

  assign c_abs_c = OUT_W'(c_mag_c[MAG_W-1:CAR_SH]);

  always_ff @(posedge clk) begin
    if (adv) out_amp <= d_neg ? $signed(OUT_W'(0) - c_abs_c) : $signed(c_abs_c);
  end

  if (CARM_W >= OUT_W) begin : g_width_guard
    initial $display("pm_amp_unit: OUT_W narrower than carrier magnitude");
  end
endmodule

// File: rtl/pm_amp_unit_chk.sv
module pm_amp_unit_chk (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic signed [7:0] out_amp
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_amp)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  idle_open_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R7
  amp_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_amp != -8'sd128));
endmodule

bind pm_amp_unit pm_amp_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp));

// File: tb/test_pm_amp_unit.sv
module test_pm_amp_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_fnum = '0;
  logic [2:0]        in_block = '0;
  logic [3:0]        in_mul_mod = '0, in_mul_car = '0;
  logic [5:0]        in_mod_level = '0;
  logic [3:0]        in_car_vol = '0;
  logic              in_mod_en = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic signed [7:0] out_amp;

  pm_amp_unit i_pm_amp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fnum(in_fnum), .in_block(in_block), .in_mul_mod(in_mul_mod),
    .in_mul_car(in_mul_car), .in_mod_level(in_mod_level),
    .in_car_vol(in_car_vol), .in_mod_en(in_mod_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp));

  int    n_chk = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  int    rdy_mode = 0;

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference curves written from R3 and R4
  function automatic longint ref_log(longint i);
    longint p, s, f, n;
    p = 2 * i + 1;
    s = ((16 * p * (1024 - p)) << 16) / (5 * 1024 * 1024 - 4 * p * (1024 - p));
    n = 0;
    for (int b = 0; b < 40; b++) if ((s >> b) != 0) n = b;
    f = (n >= 8) ? ((s >> (n - 8)) & 255) : ((s << (8 - n)) & 255);
    return (16 - n) * 256 - ((f * (88320 - 89 * f)) >> 16);
  endfunction

  function automatic longint ref_mag(longint a);
    longint g, k;
    g = 255 - (a & 255);
    k = a >> 8;
    if (k >= 11) return 0;
    return (1024 + ((g * (172032 + 352 * g)) >> 16)) >> k;
  endfunction

  function automatic longint ref_fold(longint x, output bit neg);
    neg = x[9];
    return x[8] ? 255 - (x & 255) : (x & 255);
  endfunction

  function automatic int ref_amp(int fn, int bl, int mm, int mc, int tl, int vol, int en);
    longint base, mi, ci, mv, cv, q;
    bit ng;
    base = longint'(fn) << bl;
    mi = ((base * mm) >> 10) & 1023;
    q  = ref_fold(mi, ng);
    mv = ref_mag(ref_log(q) + 32 * tl) >> 1;
    if (ng) mv = -mv;
    ci = (((base * mc) >> 10) + (en != 0 ? 2 * mv : 0)) & 1023;
    q  = ref_fold(ci, ng);
    cv = ref_mag(ref_log(q) + 128 * vol) >> 4;
    return int'(ng ? -cv : cv);
  endfunction

  task automatic send(int fn, int bl, int mm, int mc, int tl, int vol, int en, string tag);
    bit got = 0;
    @(negedge clk);
    in_fnum = 8'(fn); in_block = 3'(bl); in_mul_mod = 4'(mm); in_mul_car = 4'(mc);
    in_mod_level = 6'(tl); in_car_vol = 4'(vol); in_mod_en = en[0];
    in_valid = 1'b1;
    while (!got) begin
      #2;
      if (in_ready) begin
        exp_q.push_back(ref_amp(fn, bl, mm, mc, tl, vol, en));
        tag_q.push_back(tag);
        @(posedge clk);
        got = 1;
      end else begin
        @(negedge clk);
      end
    end
    #1 in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= ($urandom_range(0, 3) != 0);
      default: out_ready <= 1'b0;
    endcase
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    #3;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected output", int'(out_amp), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(out_amp) == e, t, int'(out_amp), e);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    longint c0;
    int k, held;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);

    // Directed cases
    send(0, 0, 1, 1, 0, 0, 1, "R3 R5 zero phase");
    send(255, 7, 15, 15, 0, 0, 1, "R1 full phase");
    send(128, 2, 1, 1, 0, 0, 0, "R2 mirrored quarter");
    send(200, 6, 1, 1, 0, 0, 0, "R2 negative half");
    send(77, 4, 2, 3, 10, 2, 1, "R4 mid attenuation");
    send(200, 5, 3, 7, 0, 0, 0, "R6 modulation off level 0");
    send(200, 5, 9, 7, 63, 0, 0, "R6 modulation off level 63");
    send(200, 5, 3, 7, 0, 0, 1, "R6 modulation on");
    send(31, 3, 5, 1, 0, 0, 1, "R5 strong modulator");
    send(31, 3, 5, 1, 40, 0, 1, "R5 weak modulator");
    send(90, 6, 1, 2, 5, 0, 1, "R7 signed carrier");
    send(0, 0, 1, 1, 0, 15, 1, "R11 heavy attenuation");
    drain();

    // R6: outputs with modulation off must match regardless of modulator settings
    begin
      int a0, a1;
      a0 = ref_amp(150, 4, 0, 5, 0, 3, 0);
      a1 = ref_amp(150, 4, 0, 5, 0, 3, 1);
      send(150, 4, 15, 5, 63, 3, 0, "R6 ignored modulator");
      send(150, 4, 0, 5, 0, 3, 0, "R6 ignored modulator base");
      drain();
      check(a0 == ref_amp(150, 4, 15, 5, 63, 3, 0), "R6 model consistency", a0, a1);
    end
    check(ref_amp(0, 0, 1, 1, 0, 15, 1) == 0, "R11 expected zero", ref_amp(0, 0, 1, 1, 0, 15, 1), 0);

    // R8 latency
    send(60, 5, 2, 2, 8, 1, 1, "R8 latency item");
    k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #3;
      k++;
      if (out_valid) break;
    end
    check(k == 5, "R8 latency", k, 5);
    drain();

    // R8 throughput
    send(1, 1, 1, 1, 1, 1, 1, "R8 burst");
    c0 = cyc;
    for (int i = 2; i <= 20; i++) send(i * 11, i % 8, i % 16, (i * 3) % 16, i, i % 16, i % 2, "R8 burst");
    check(cyc - c0 == 19, "R8 no gaps", int'(cyc - c0), 19);
    drain();

    // R9 back-pressure
    rdy_mode = 2;
    for (int i = 0; i < 5; i++) send(40 + i * 30, 5, 3, 1, 4, 0, 1, "R9 held result");
    @(negedge clk); #3;
    check(out_valid == 1'b1, "R9 result present", int'(out_valid), 1);
    check(in_ready == 1'b0, "R9 input blocked", int'(in_ready), 0);
    held = int'(out_amp);
    repeat (4) @(negedge clk);
    #3;
    check(int'(out_amp) == held, "R9 result held", int'(out_amp), held);
    check(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
    rdy_mode = 1;
    drain();

    // Random traffic
    for (int i = 0; i < 400; i++)
      send($urandom_range(0, 255), $urandom_range(0, 7), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 63), $urandom_range(0, 15),
           $urandom_range(0, 1), "R1 R5 R6 R7 random");
    drain();
    finish_run();
  end

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
endmodule